// File: doc/BRIEF.md
# Segmented Best-Fit Heap Allocator

This block hands out and takes back blocks of local memory for a hardware thread. It provides lightweight malloc and free services. The heap sits at the top of the local address range and is split up front into three pools of fixed-size segments: 8-byte, 32-byte and 1024-byte. A bitmap per pool records which segments are taken. A malloc names a byte size and receives the address of a segment from the smallest pool whose segment holds that size. A free names an address and returns the segment it denotes to its pool.

A request for more than 1024 bytes does not use the pools. It is served from a single large region. The region's start is found by moving a heap pointer down from the bottom of the pools by the request, rounded up to whole 4-byte words. Only one such large block may be live at a time. A request that cannot be met returns address zero. Pools never merge or split, so the block has no defragmentation step.

Each request occupies one cycle on the request pins. Its answer appears on the response pins one clock later. Software-visible ownership rules, such as which thread may free which block, are left to the caller.

Top module: `heap_alloc`

## Requirements
- R1: After reset every segment and the oversize region are free, and `respValid` and `freeErr` are low.
- R2: A malloc of 1 to 8 bytes returns `P8 + 8*i`, where `P8 = TOP - N1K*1024 - N32*32 - N8*8`, `TOP = BASE + MEM_BYTES`, and `i` is the index of a free 8-byte segment.
- R3: A malloc of 9 to 32 bytes returns `P32 + 32*i`, with `P32 = TOP - N1K*1024 - N32*32`. A malloc of 33 to 1024 bytes returns `P1K + 1024*i`, with `P1K = TOP - N1K*1024`.
- R4: When the best-fit pool has no free segment, the next larger pool is tried, then the one after it. The oversize region is never used for requests of 1024 bytes or less.
- R5: Within a pool the free segment with the lowest index is chosen.
- R6: A malloc above 1024 bytes returns `P8 - roundup4(size)` if no oversize block is live and `roundup4(size) <= P8 - (BASE + FLOOR_OFF)`. A second oversize malloc while one is live returns 0.
- R7: A malloc of size 0, or one that no pool or the oversize region can serve, returns 0 and changes no state.
- R8: A free of the exact start address of a taken segment marks it free, and later mallocs may hand it out again. The response address is 0 and `freeErr` is low.
- R9: A free whose address is not the start of a taken segment, and not the start of the live oversize block, changes no state and raises `freeErr` for that response.
- R10: A free of the live oversize block's start address releases it, so a new oversize malloc is served again from `P8`.
- R11: Each request cycle with `reqValid` high yields exactly one cycle of `respValid` high on the next clock. Idle cycles yield none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqIsFree | input | 1 | 1 = free, 0 = malloc |
| reqSize | input | 16 | Malloc size in bytes |
| reqAddr | input | 32 | Address to free |
| respValid | output | 1 | Response to the previous cycle's request |
| respAddr | output | 32 | Allocated address, or 0 |
| freeErr | output | 1 | The previous free matched no taken block |

## Verification
The bench fills the 8-byte pool until mallocs spill into the 32-byte pool and then into the 1024-byte pool. A design without fallback would return null too early. A design that skipped a pool would return an address in the wrong range. Sizes at the pool edges (8/9, 32/33, 1024/1025) and size zero catch an off-by-one in class selection. An oversize request exactly equal to the spare space, one word beyond it, and a second oversize while one is live catch a wrong bound or a missing single-block rule. Frees of unaligned, never-taken and twice-freed addresses must leave every bitmap untouched. This shows up when later mallocs return exactly the model's lowest-index addresses.

// File: rtl/heap_alloc_pkg.sv
package heap_alloc_pkg;

  typedef struct packed {
    logic respond;
    logic alloc8;
    logic alloc32;
    logic alloc1k;
    logic allocOvr;
    logic free8;
    logic free32;
    logic free1k;
    logic freeOvr;
    logic freeErr;
  } heapStrb_t;

  typedef struct packed {
    logic avail8;
    logic avail32;
    logic avail1k;
    logic ovrOpen;
    logic hit8;
    logic hit32;
    logic hit1k;
    logic hitOvr;
  } heapStat_t;

endpackage

// File: rtl/heap_seg_pool.sv
module heap_seg_pool #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BASE      = 0,
  parameter int unsigned SEG_BYTES = 8,
  parameter int unsigned COUNT     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocEn,
  input  logic              freeEn,
  input  logic [ADDR_W-1:0] probeAddr,
  output logic              avail,
  output logic [ADDR_W-1:0] allocAddr,
  output logic              probeHit
);
  localparam int unsigned IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam int unsigned SHIFT = $clog2(SEG_BYTES);
  localparam int unsigned SPAN  = COUNT * SEG_BYTES;

  logic [COUNT-1:0]  usedMap;
  logic [IDX_W-1:0]  pickIdx;
  logic [IDX_W-1:0]  probeIdx;
  logic [ADDR_W-1:0] probeOff;
  logic              inRange;
  logic              aligned;

  // lowest free index wins
  always_comb begin
    avail   = 1'b0;
    pickIdx = '0;
    for (int i = COUNT - 1; i >= 0; i--) begin
      if (!usedMap[i]) begin
        avail   = 1'b1;
        pickIdx = IDX_W'(i);
      end
    end
  end

  assign allocAddr = ADDR_W'(BASE) + (ADDR_W'(pickIdx) << SHIFT);

  always_comb begin
    probeOff = probeAddr - ADDR_W'(BASE);
    inRange  = (probeAddr >= ADDR_W'(BASE)) && (probeOff < ADDR_W'(SPAN));
    aligned  = (probeOff[SHIFT-1:0] == '0);
    probeIdx = IDX_W'(probeOff >> SHIFT);
    probeHit = inRange && aligned && usedMap[probeIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usedMap <= '0;
    end else begin
      if (allocEn) usedMap[pickIdx]  <= 1'b1;
      if (freeEn)  usedMap[probeIdx] <= 1'b0;
    end
  end

endmodule

// File: rtl/heap_ctrl.sv
module heap_ctrl
  import heap_alloc_pkg::*;
#(
  parameter int unsigned SIZE_W = 16
) (
  input  logic              reqValid,
  input  logic              reqIsFree,
  input  logic [SIZE_W-1:0] reqSize,
  input  heapStat_t         stat,
  output heapStrb_t         strb
);
  logic isMalloc;
  logic isFree;
  logic clsSmall;
  logic clsMid;
  logic clsBig;
  logic clsHuge;
  logic want32;
  logic want1k;

  always_comb begin
    isMalloc = reqValid && !reqIsFree;
    isFree   = reqValid && reqIsFree;
    clsSmall = (reqSize != '0) && (reqSize <= SIZE_W'(8));
    clsMid   = (reqSize > SIZE_W'(8)) && (reqSize <= SIZE_W'(32));
    clsBig   = (reqSize > SIZE_W'(32)) && (reqSize <= SIZE_W'(1024));
    clsHuge  = reqSize > SIZE_W'(1024);
    want32   = (clsSmall && !stat.avail8) || clsMid;
    want1k   = (want32 && !stat.avail32) || clsBig;

    strb          = '0;
    strb.respond  = reqValid;
    strb.alloc8   = isMalloc && clsSmall && stat.avail8;
    strb.alloc32  = isMalloc && want32 && stat.avail32;
    strb.alloc1k  = isMalloc && want1k && stat.avail1k;
    strb.allocOvr = isMalloc && clsHuge && stat.ovrOpen;
    strb.free8    = isFree && stat.hit8;
    strb.free32   = isFree && stat.hit32;
    strb.free1k   = isFree && stat.hit1k;
    strb.freeOvr  = isFree && stat.hitOvr;
    strb.freeErr  = isFree && !(stat.hit8 || stat.hit32 || stat.hit1k || stat.hitOvr);
  end

endmodule

// File: rtl/heap_dp.sv
module heap_dp
  import heap_alloc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SIZE_W    = 16,
  parameter int unsigned BASE      = 32'h0001_0000,
  parameter int unsigned MEM_BYTES = 16384,
  parameter int unsigned FLOOR_OFF = 4096,
  parameter int unsigned N8        = 8,
  parameter int unsigned N32       = 8,
  parameter int unsigned N1K       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  heapStrb_t         strb,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  output heapStat_t         stat,
  output logic              respValid,
  output logic [ADDR_W-1:0] respAddr,
  output logic              freeErr
);
  localparam int unsigned TOP     = BASE + MEM_BYTES;
  localparam int unsigned P1K     = TOP - N1K * 1024;
  localparam int unsigned P32     = P1K - N32 * 32;
  localparam int unsigned P8      = P32 - N8 * 8;
  localparam int unsigned OVR_CAP = P8 - (BASE + FLOOR_OFF);

  logic [ADDR_W-1:0] addr8, addr32, addr1k;
  logic [ADDR_W-1:0] ovrAddr;
  logic [ADDR_W-1:0] ovrCand;
  logic [SIZE_W:0]   roundSize;
  logic              ovrUsed;
  logic              ovrFits;
  logic [ADDR_W-1:0] nextAddr;

  heap_seg_pool #(.ADDR_W(ADDR_W), .BASE(P8), .SEG_BYTES(8), .COUNT(N8)) u_pool8 (
    .clk(clk), .rstN(rstN), .allocEn(strb.alloc8), .freeEn(strb.free8),
    .probeAddr(reqAddr), .avail(stat.avail8), .allocAddr(addr8), .probeHit(stat.hit8));

  heap_seg_pool #(.ADDR_W(ADDR_W), .BASE(P32), .SEG_BYTES(32), .COUNT(N32)) u_pool32 (
    .clk(clk), .rstN(rstN), .allocEn(strb.alloc32), .freeEn(strb.free32),
    .probeAddr(reqAddr), .avail(stat.avail32), .allocAddr(addr32), .probeHit(stat.hit32));

  heap_seg_pool #(.ADDR_W(ADDR_W), .BASE(P1K), .SEG_BYTES(1024), .COUNT(N1K)) u_pool1k (
    .clk(clk), .rstN(rstN), .allocEn(strb.alloc1k), .freeEn(strb.free1k),
    .probeAddr(reqAddr), .avail(stat.avail1k), .allocAddr(addr1k), .probeHit(stat.hit1k));

  always_comb begin
    roundSize    = ({1'b0, reqSize} + (SIZE_W+1)'(3)) & ~(SIZE_W+1)'(3);
    ovrFits      = ADDR_W'(roundSize) <= ADDR_W'(OVR_CAP);
    ovrCand      = ADDR_W'(P8) - ADDR_W'(roundSize);
    stat.ovrOpen = !ovrUsed && ovrFits;
    stat.hitOvr  = ovrUsed && (reqAddr == ovrAddr);
  end

  always_comb begin
    nextAddr = '0;
    if (strb.alloc8)   nextAddr = addr8;
    if (strb.alloc32)  nextAddr = addr32;
    if (strb.alloc1k)  nextAddr = addr1k;
    if (strb.allocOvr) nextAddr = ovrCand;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovrUsed   <= 1'b0;
      ovrAddr   <= '0;
      respValid <= 1'b0;
      respAddr  <= '0;
      freeErr   <= 1'b0;
    end else begin
      if (strb.allocOvr) begin
        ovrUsed <= 1'b1;
        ovrAddr <= ovrCand;
      end else if (strb.freeOvr) begin
        ovrUsed <= 1'b0;
      end
      respValid <= strb.respond;
      respAddr  <= nextAddr;
      freeErr   <= strb.freeErr;
    end
  end

endmodule

// File: rtl/heap_alloc.sv
module heap_alloc
  import heap_alloc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SIZE_W    = 16,
  parameter int unsigned BASE      = 32'h0001_0000,
  parameter int unsigned MEM_BYTES = 16384,
  parameter int unsigned FLOOR_OFF = 4096,
  parameter int unsigned N8        = 8,
  parameter int unsigned N32       = 8,
  parameter int unsigned N1K       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsFree,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              respValid,
  output logic [ADDR_W-1:0] respAddr,
  output logic              freeErr
);
  heapStrb_t strb;
  heapStat_t stat;

  heap_ctrl #(.SIZE_W(SIZE_W)) u_ctrl (
    .reqValid(reqValid), .reqIsFree(reqIsFree), .reqSize(reqSize),
    .stat(stat), .strb(strb));

  heap_dp #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BASE(BASE), .MEM_BYTES(MEM_BYTES),
    .FLOOR_OFF(FLOOR_OFF), .N8(N8), .N32(N32), .N1K(N1K)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqSize(reqSize), .reqAddr(reqAddr),
    .stat(stat), .respValid(respValid), .respAddr(respAddr), .freeErr(freeErr));

endmodule

// File: rtl/heap_alloc_chk.sv
module heap_alloc_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SIZE_W    = 16,
  parameter int unsigned BASE      = 32'h0001_0000,
  parameter int unsigned MEM_BYTES = 16384,
  parameter int unsigned FLOOR_OFF = 4096
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqIsFree,
  input logic [SIZE_W-1:0] reqSize,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              respValid,
  input logic [ADDR_W-1:0] respAddr,
  input logic              freeErr
);
  localparam int unsigned TOP   = BASE + MEM_BYTES;
  localparam int unsigned FLOOR = BASE + FLOOR_OFF;

  // R11
  p_resp_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);
  // R7
  p_zero_size_null_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIsFree && reqSize == '0) |=> (respAddr == '0));
  // R9
  p_err_after_free_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIsFree) |=> !freeErr);
  // R8
  p_free_null_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsFree) |=> (respAddr == '0));
  // R2
  p_small_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIsFree && reqSize != '0 && reqSize <= SIZE_W'(8))
      |=> (respAddr[2:0] == 3'b000));
  // R6
  p_in_heap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respAddr != '0)
      |-> (respAddr >= ADDR_W'(FLOOR) && respAddr < ADDR_W'(TOP)));

endmodule

bind heap_alloc heap_alloc_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BASE(BASE), .MEM_BYTES(MEM_BYTES), .FLOOR_OFF(FLOOR_OFF)
) u_heap_alloc_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsFree(reqIsFree),
  .reqSize(reqSize), .reqAddr(reqAddr), .respValid(respValid),
  .respAddr(respAddr), .freeErr(freeErr));

// File: tb/test_heap_alloc.sv
`timescale 1ns/1ps
module test_heap_alloc;
  localparam int unsigned BASE = 32'h0001_0000;
  localparam int unsigned TOP  = BASE + 16384;
  localparam int unsigned P1K  = TOP - 4 * 1024;
  localparam int unsigned P32  = P1K - 8 * 32;
  localparam int unsigned P8   = P32 - 8 * 8;
  localparam int unsigned CAP  = P8 - (BASE + 4096);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIsFree = 1'b0;
  logic [15:0] reqSize = '0;
  logic [31:0] reqAddr = '0;
  logic        respValid;
  logic [31:0] respAddr;
  logic        freeErr;

  int  testCount = 0;
  int  failCount = 0;
  bit  finished = 1'b0;

  logic [7:0] m8, m32;
  logic [3:0] m1k;
  logic       mOvr;
  logic [31:0] mOvrAddr;

  always #2.5 clk = ~clk;

  heap_alloc i_heap_alloc (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsFree(reqIsFree),
    .reqSize(reqSize), .reqAddr(reqAddr), .respValid(respValid),
    .respAddr(respAddr), .freeErr(freeErr));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lowFree(input logic [7:0] map, input int n);
    for (int i = 0; i < n; i++) if (!map[i]) return i;
    return -1;
  endfunction

  // reference model of R2..R7
  task automatic modelMalloc(input int sz, output logic [31:0] a);
    int k;
    a = 0;
    if (sz == 0) return;
    if (sz > 1024) begin
      int r = (sz + 3) & ~3;
      if (!mOvr && r <= int'(CAP)) begin
        mOvr = 1; mOvrAddr = P8 - r; a = mOvrAddr;
      end
      return;
    end
    if (sz <= 8) begin
      k = lowFree(m8, 8);
      if (k >= 0) begin m8[k] = 1; a = P8 + 8 * k; return; end
    end
    if (sz <= 32) begin
      k = lowFree(m32, 8);
      if (k >= 0) begin m32[k] = 1; a = P32 + 32 * k; return; end
    end
    k = lowFree({4'b1111, m1k}, 4);
    if (k >= 0) begin m1k[k] = 1; a = P1K + 1024 * k; end
  endtask

  task automatic modelFree(input logic [31:0] a, output bit err);
    err = 1;
    if (a >= P8 && a < P32 && a[2:0] == 0 && m8[(a - P8) >> 3]) begin m8[(a - P8) >> 3] = 0; err = 0; end
    else if (a >= P32 && a < P1K && a[4:0] == 0 && m32[(a - P32) >> 5]) begin m32[(a - P32) >> 5] = 0; err = 0; end
    else if (a >= P1K && a < TOP && a[9:0] == 0 && m1k[(a - P1K) >> 10]) begin m1k[(a - P1K) >> 10] = 0; err = 0; end
    else if (mOvr && a == mOvrAddr) begin mOvr = 0; err = 0; end
  endtask

  task automatic doMalloc(input int sz, input string tag);
    logic [31:0] e;
    modelMalloc(sz, e);
    @(negedge clk);
    reqValid = 1; reqIsFree = 0; reqSize = 16'(sz); reqAddr = '0;
    @(negedge clk);
    reqValid = 0;
    check(respValid === 1'b1, "R11 respValid", {31'b0, respValid}, 1);
    check(respAddr === e, tag, respAddr, e);
  endtask

  task automatic doFree(input logic [31:0] a, input string tag);
    bit e;
    modelFree(a, e);
    @(negedge clk);
    reqValid = 1; reqIsFree = 1; reqSize = '0; reqAddr = a;
    @(negedge clk);
    reqValid = 0;
    check(freeErr === e, tag, {31'b0, freeErr}, {31'b0, e});
    check(respAddr === 32'h0, "R8 free resp", respAddr, 0);
  endtask

  initial begin
    int seed;
    m8 = 0; m32 = 0; m1k = 0; mOvr = 0; mOvrAddr = 0;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(respValid === 1'b0 && freeErr === 1'b0, "R1 reset outputs", {30'b0, respValid, freeErr}, 0);
    @(negedge clk);
    check(respValid === 1'b0, "R11 idle no resp", {31'b0, respValid}, 0);

    doMalloc(5, "R2 first small");
    check(respAddr === P8, "R2 literal", respAddr, P8);
    doMalloc(8, "R2 edge 8");
    doMalloc(9, "R3 edge 9");
    check(respAddr === P32, "R3 literal", respAddr, P32);
    doMalloc(32, "R3 edge 32");
    doMalloc(33, "R3 edge 33");
    doMalloc(1024, "R3 edge 1024");
    doMalloc(0, "R7 zero size");
    doFree(P8, "R8 free first small");
    doMalloc(1, "R5 reuse lowest");
    check(respAddr === P8, "R5 literal", respAddr, P8);
    doFree(P8 + 4, "R9 unaligned free");
    doFree(P8 + 56, "R9 never taken");
    doMalloc(3, "R9 state unchanged");
    doMalloc(1025, "R6 first oversize");
    check(respAddr === P8 - 1028, "R6 literal", respAddr, P8 - 1028);
    doMalloc(2000, "R6 second oversize null");
    doFree(P8 - 1028, "R10 free oversize");
    doFree(P8 - 1028, "R9 double free");
    doMalloc(int'(CAP) + 1, "R6 just beyond cap");
    doMalloc(int'(CAP), "R10 exact cap");
    doFree(BASE + 4096, "R10 release cap");
    for (int i = 0; i < 14; i++) doMalloc(2, "R4 spill small");
    doMalloc(20, "R7 exhaust mid");

    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom % 10);
      if (op < 5) begin
        int cls = int'($urandom % 5);
        int sz;
        case (cls)
          0: sz = int'($urandom % 9);
          1: sz = 9 + int'($urandom % 24);
          2: sz = 33 + int'($urandom % 992);
          3: sz = 1025 + int'($urandom % 7000);
          default: sz = int'($urandom % 1100);
        endcase
        doMalloc(sz, "R4 random malloc");
      end else begin
        int p = int'($urandom % 4);
        logic [31:0] a;
        case (p)
          0: a = P8 + 8 * ($urandom % 8);
          1: a = P32 + 32 * ($urandom % 8);
          2: a = P1K + 1024 * ($urandom % 4);
          default: a = mOvr ? mOvrAddr : P32 + 4;
        endcase
        doFree(a, "R8 random free");
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule